// File: doc/BRIEF.md
# Station Address PROM Access Decoder

This block sits on the slave side of a network controller. It decodes every host access that lands in the controller's small address windows. A 16-byte station address store holds the node's hardware address. Next to it is a downstream register port that leads to the controller's internal 16-bit and 32-bit registers. Each request carries a window select (port I/O or memory-mapped), a size code, an address and write data. The decoder chooses one of three outcomes:

- access the address bytes;
- pass the request to the register port for exactly one cycle;
- refuse it. A refused read returns all ones at the access width, and a refused write is dropped.

Multi-byte address-store accesses are split into bytes, or put together from bytes, in little-endian order. Two control inputs shape the decode. A doubleword-mode input sets which sizes are legal in the I/O window. A write-enable input guards the address bytes against host writes. A separate preload port can fill the address bytes at any time, without regard to the write-enable input.

A two-state controller produces the read reply. `ST_IDLE` is the resting state. A read request in any state moves the controller to `ST_REPLY`. While in `ST_REPLY` the controller drives the captured reply with a valid strobe. A cycle with no read request returns it to `ST_IDLE`, and another read keeps it in `ST_REPLY`. Writes never leave `ST_IDLE`.

Top module: `sprom_access`

## Requirements
- R1: After reset, all 16 address bytes read as zero, `rd_valid` is low and `rp_en` is low.
- R2: A read request in cycle N gives `rd_valid` high in cycle N+1 only, unless another read follows. Back-to-back reads give one reply per cycle, in order. A write request never raises `rd_valid`.
- R3: A host write to the address bytes changes them only while `prom_wen` is 1. When `prom_wen` is 0, the stored bytes stay unchanged.
- R4: When `ld_en` is 1, byte `ld_idx` is loaded with `ld_byte` on the next clock edge, whatever the value of `prom_wen`. If a host write hits the same byte in the same cycle, the load wins.
- R5: Size codes are 0 = byte, 1 = word (16 bits), 2 = doubleword (32 bits) and 3 = reserved. In the I/O window (`req_mem`=0), offsets 0x00–0x0F reach the address bytes under these rules:
  - a byte access is legal only when `mode_dword`=0;
  - a word access is legal only when `mode_dword`=0 and the offset is even;
  - a doubleword access is legal only when `mode_dword`=1 and the offset is a multiple of 4.
- R6: A read with no legal target returns ones in the access width only: 0x000000FF for a byte, 0x0000FFFF for a word, and 0xFFFFFFFF for a doubleword or the reserved code. A write with no legal target changes nothing and does not pulse `rp_en`.
- R7: Multi-byte address-store data are little-endian. The byte at the start offset is on `rd_data`/`req_wdata` bits 7:0. Each following byte takes the next higher 8-bit lane. Unused upper read bits are zero.
- R8: In the I/O window, offsets 0x10 and above go to the register port only for word and doubleword accesses. `rp_offset` is the full request address. Byte and reserved-size accesses there are refused, as in R6.
- R9: In the memory window (`req_mem`=1) with address bit 4 clear, the address bytes are reached for byte, word and doubleword sizes:
  - the start byte is address bits 3:0;
  - there is no alignment rule, and `mode_dword` has no effect;
  - byte positions wrap modulo 16.
- R10: In the memory window with address bit 4 set, word and doubleword accesses go to the register port with `rp_offset` = address bits 3:0. Byte and reserved-size accesses there are refused.
- R11: A forwarded access drives the register port in the request cycle only:
  - `rp_en` is high;
  - `rp_write` follows the request;
  - `rp_dword` is 1 for a doubleword;
  - `rp_wdata` equals `req_wdata`.
  A forwarded read returns `rp_rdata` masked to the access width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_dword | input | 1 | Doubleword I/O mode for the I/O window |
| prom_wen | input | 1 | Host write enable for the address bytes |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory window, 0 = I/O window |
| req_size | input | 2 | 0 byte, 1 word, 2 doubleword, 3 reserved |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_wdata | input | 32 | Write data, little-endian lanes |
| rd_valid | output | 1 | Read reply strobe |
| rd_data | output | 32 | Read reply data |
| ld_en | input | 1 | Preload strobe |
| ld_idx | input | 4 | Preload byte index |
| ld_byte | input | 8 | Preload byte value |
| rp_en | output | 1 | Register port access strobe |
| rp_write | output | 1 | Register port write flag |
| rp_dword | output | 1 | Register port width, 1 = 32 bits, 0 = 16 bits |
| rp_offset | output | ADDR_W | Register port offset |
| rp_wdata | output | 32 | Register port write data |
| rp_rdata | input | 32 | Register port read data, same cycle |

## Verification
The failures to watch for show up in the wrong place or at the wrong time:

- **Wrong legality decision.** The error appears in the very next reply as an all-ones value where data was expected, or the other way round. It can also show as an `rp_en` pulse in the request cycle itself.
- **Wrong lane or wrap index.** This shows only on a later read, as bytes that are swapped or misplaced. So every write scenario is followed by reads of each byte it could have touched, including across the 15-to-0 wrap.
- **Corrupted reply state.** A missing or extra `rd_valid`, or a stale reply during back-to-back reads, shows one cycle after the request.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

    localparam int PROM_BYTES = 16;
    localparam int IDX_W      = $clog2(PROM_BYTES);
    localparam int LANES      = 4;
    localparam int DATA_W     = 8 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PROM = 2'd1,
        TGT_REG  = 2'd2
    } tgt_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } st_e;

    // Ones across the access width; the reserved code counts as full width.
    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
        unique case (sz)
            SZ_BYTE: width_mask = DATA_W'(32'h0000_00FF);
            SZ_WORD: width_mask = DATA_W'(32'h0000_FFFF);
            default: width_mask = {DATA_W{1'b1}};
        endcase
    endfunction

    // Byte lanes touched by a store access of the given size.
    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz);
        unique case (sz)
            SZ_BYTE: lane_mask = LANES'(4'b0001);
            SZ_WORD: lane_mask = LANES'(4'b0011);
            default: lane_mask = {LANES{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/sprom_decode.sv
module sprom_decode
    import sprom_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              mem_win,
    input  logic              mode_dword,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt,
    output logic [IDX_W-1:0]  base,
    output logic [LANES-1:0]  lanes,
    output logic [ADDR_W-1:0] rp_off
);

    logic io_low;
    logic io_legal;
    logic fwd_size;

    // Offsets below 0x10: every bit above bit 3 is zero.
    assign io_low   = (addr[ADDR_W-1:IDX_W] == '0);
    assign fwd_size = (size == SZ_WORD) || (size == SZ_DWORD);

    always_comb begin
        unique case (size_e'(size))
            SZ_BYTE:  io_legal = !mode_dword;
            SZ_WORD:  io_legal = !mode_dword && !addr[0];
            SZ_DWORD: io_legal = mode_dword && (addr[1:0] == 2'b00);
            default:  io_legal = 1'b0;
        endcase
    end

    always_comb begin
        tgt    = TGT_NONE;
        base   = addr[IDX_W-1:0];
        lanes  = lane_mask(size);
        rp_off = addr;
        if (!mem_win) begin
            if (io_low) begin
                tgt = io_legal ? TGT_PROM : TGT_NONE;
            end else begin
                tgt = fwd_size ? TGT_REG : TGT_NONE;
            end
        end else begin
            rp_off = ADDR_W'(addr[IDX_W-1:0]);
            if (!addr[IDX_W]) begin
                tgt = (size != SZ_RSVD) ? TGT_PROM : TGT_NONE;
            end else begin
                tgt = fwd_size ? TGT_REG : TGT_NONE;
            end
        end
    end

endmodule

// File: rtl/sprom_cells.sv
module sprom_cells
    import sprom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  base,
    input  logic [LANES-1:0]  lanes,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [7:0]        ld_byte,
    output logic [DATA_W-1:0] rd_lanes
);

    logic [8*PROM_BYTES-1:0] flat;

    for (genvar j = 0; j < PROM_BYTES; j++) begin : g_cell
        logic [7:0] cell_q;
        logic [7:0] cell_d;

        always_comb begin
            cell_d = cell_q;
            for (int k = 0; k < LANES; k++) begin
                if (wr_en && lanes[k] && ((base + IDX_W'(k)) == IDX_W'(j))) begin
                    cell_d = wdata[8*k +: 8];
                end
            end
            if (ld_en && (ld_idx == IDX_W'(j))) begin
                cell_d = ld_byte;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cell_q <= '0;
            else        cell_q <= cell_d;
        end

        assign flat[8*j +: 8] = cell_q;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        logic [IDX_W-1:0] ridx;
        assign ridx = base + IDX_W'(k);
        assign rd_lanes[8*k +: 8] = flat[{ridx, 3'b000} +: 8];
    end

    // R3: with neither a gated write nor a load, the store must hold.
    p_hold_when_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ld_en) |=> (flat == $past(flat)));

    // R4: a load lands on the addressed byte.
    p_load_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (flat[{$past(ld_idx), 3'b000} +: 8] == $past(ld_byte)));

endmodule

// File: rtl/sprom_access.sv
module sprom_access
    import sprom_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_dword,
    input  logic              prom_wen,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              ld_en,
    input  logic [3:0]        ld_idx,
    input  logic [7:0]        ld_byte,
    output logic              rp_en,
    output logic              rp_write,
    output logic              rp_dword,
    output logic [ADDR_W-1:0] rp_offset,
    output logic [31:0]       rp_wdata,
    input  logic [31:0]       rp_rdata
);

    tgt_e              tgt;
    logic [IDX_W-1:0]  base;
    logic [LANES-1:0]  lanes;
    logic [ADDR_W-1:0] dec_off;
    logic [DATA_W-1:0] prom_rd;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] reply_d;
    logic              cell_wr;
    logic              rd_req;

    st_e               state_q;
    st_e               state_d;
    logic [DATA_W-1:0] rdata_q;

    sprom_decode #(.ADDR_W(ADDR_W)) u_decode (
        .mem_win    (req_mem),
        .mode_dword (mode_dword),
        .size       (req_size),
        .addr       (req_addr),
        .tgt        (tgt),
        .base       (base),
        .lanes      (lanes),
        .rp_off     (dec_off)
    );

    assign cell_wr = req_valid && req_write && (tgt == TGT_PROM) && prom_wen;
    assign rd_req  = req_valid && !req_write;

    sprom_cells u_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cell_wr),
        .base     (base),
        .lanes    (lanes),
        .wdata    (req_wdata),
        .ld_en    (ld_en),
        .ld_idx   (ld_idx),
        .ld_byte  (ld_byte),
        .rd_lanes (prom_rd)
    );

    assign mask = width_mask(req_size);

    always_comb begin
        unique case (tgt)
            TGT_PROM: reply_d = prom_rd & mask;
            TGT_REG:  reply_d = rp_rdata & mask;
            default:  reply_d = mask;
        endcase
    end

    // Register port: live only in the request cycle.
    assign rp_en     = req_valid && (tgt == TGT_REG);
    assign rp_write  = req_write;
    assign rp_dword  = (req_size == SZ_DWORD);
    assign rp_offset = dec_off;
    assign rp_wdata  = req_wdata;

    // Reply controller: next state.
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = rd_req ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = rd_req ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Reply controller: state register and captured reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) rdata_q <= reply_d;
        end
    end

    // Reply controller: outputs.
    always_comb begin
        rd_valid = (state_q == ST_REPLY);
        rd_data  = rdata_q;
    end

    p_reply_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    p_reply_needs_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    p_refused_reads_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (tgt == TGT_NONE)) |=> (rd_data == width_mask($past(req_size))));

    p_io_high_not_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_mem && (req_addr[ADDR_W-1:IDX_W] != '0)) |-> (tgt != TGT_PROM));

    p_port_no_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rp_en |-> ((req_size == SZ_WORD) || (req_size == SZ_DWORD)));

    p_mem_bit4_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_en && req_mem) |-> (rp_offset[ADDR_W-1:IDX_W] == '0));

endmodule

// File: tb/sprom_access_bench.sv
module sprom_access_bench;

    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_dword = 1'b0;
    logic          prom_wen = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_mem = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          ld_en = 1'b0;
    logic [3:0]    ld_idx = '0;
    logic [7:0]    ld_byte = '0;
    logic          rp_en;
    logic          rp_write;
    logic          rp_dword;
    logic [AW-1:0] rp_offset;
    logic [31:0]   rp_wdata;
    logic [31:0]   rp_rdata = 32'h1357_9BDF;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [7:0] model [16];

    always #2.5 clk = ~clk;

    sprom_access #(.ADDR_W(AW)) u_sprom_access (
        .clk(clk), .rst_n(rst_n), .mode_dword(mode_dword), .prom_wen(prom_wen),
        .req_valid(req_valid), .req_write(req_write), .req_mem(req_mem),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_byte(ld_byte),
        .rp_en(rp_en), .rp_write(rp_write), .rp_dword(rp_dword),
        .rp_offset(rp_offset), .rp_wdata(rp_wdata), .rp_rdata(rp_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // kind: 0 refused, 1 address store, 2 register port
    task automatic access(input string tag, input logic wr, input logic mem,
                          input logic [1:0] sz, input logic [AW-1:0] addr,
                          input logic [31:0] wd, input int kind);
        logic [31:0] mask;
        logic [31:0] exp;
        int n;
        mask = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        n    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        exp  = mask;
        if (kind == 1) begin
            exp = '0;
            for (int k = 0; k < n; k++) exp |= 32'(model[4'(addr[3:0] + 4'(k))]) << (8 * k);
        end else if (kind == 2) begin
            exp = rp_rdata & mask;
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_mem = mem;
        req_size = sz; req_addr = addr; req_wdata = wd;
        #1;
        check({tag, " rp_en"}, 32'(rp_en), 32'(kind == 2));
        if (kind == 2) begin
            check({tag, " rp_offset"}, 32'(rp_offset), mem ? 32'(addr[3:0]) : 32'(addr));
            check({tag, " rp_write"}, 32'(rp_write), 32'(wr));
            check({tag, " rp_dword"}, 32'(rp_dword), 32'(sz == 2'd2));
            if (wr) check({tag, " rp_wdata"}, rp_wdata, wd);
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        #1;
        check({tag, " rd_valid"}, 32'(rd_valid), 32'(!wr));
        if (!wr) check({tag, " rd_data"}, rd_data, exp);
        if (kind == 2) check({tag, " R11 rp_en one cycle"}, 32'(rp_en), 32'd0);
        if (wr && kind == 1 && prom_wen) begin
            for (int k = 0; k < n; k++) model[4'(addr[3:0] + 4'(k))] = wd[8*k +: 8];
        end
    endtask

    task automatic preload(input logic [3:0] idx, input logic [7:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_byte = val;
        @(negedge clk);
        ld_en = 1'b0;
        model[idx] = val;
    endtask

    task automatic t_reset;
        #1;
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 rp_en", 32'(rp_en), 32'd0);
        mode_dword = 1'b0;
        access("R1 byte 0", 1'b0, 1'b0, 2'd0, 5'h00, '0, 1);
        access("R1 byte 15", 1'b0, 1'b0, 2'd0, 5'h0F, '0, 1);
        mode_dword = 1'b1;
        access("R1 dword 4", 1'b0, 1'b0, 2'd2, 5'h04, '0, 1);
        mode_dword = 1'b0;
    endtask

    task automatic t_preload;
        prom_wen = 1'b0;
        for (int i = 0; i < 16; i++) preload(4'(i), 8'(8'h21 + i * 8'h13));
        access("R4 byte 7", 1'b0, 1'b0, 2'd0, 5'h07, '0, 1);
        access("R7 word 6", 1'b0, 1'b0, 2'd1, 5'h06, '0, 1);
        // Same-cycle load and host write on byte 4: the load wins.
        prom_wen = 1'b1;
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 4'd4; ld_byte = 8'h99;
        req_valid = 1'b1; req_write = 1'b1; req_mem = 1'b0;
        req_size = 2'd0; req_addr = 5'h04; req_wdata = 32'h77;
        @(negedge clk);
        ld_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        model[4] = 8'h99;
        access("R4 load beats write", 1'b0, 1'b0, 2'd0, 5'h04, '0, 1);
    endtask

    task automatic t_write_gate;
        prom_wen = 1'b0;
        access("R3 locked write", 1'b1, 1'b0, 2'd0, 5'h02, 32'hC3, 1);
        access("R3 locked readback", 1'b0, 1'b0, 2'd0, 5'h02, '0, 1);
        prom_wen = 1'b1;
        access("R3 open write", 1'b1, 1'b0, 2'd0, 5'h02, 32'hC3, 1);
        access("R3 open readback", 1'b0, 1'b0, 2'd0, 5'h02, '0, 1);
        access("R7 word write", 1'b1, 1'b0, 2'd1, 5'h08, 32'hBEEF, 1);
        access("R7 low lane", 1'b0, 1'b0, 2'd0, 5'h08, '0, 1);
        access("R7 high lane", 1'b0, 1'b0, 2'd0, 5'h09, '0, 1);
    endtask

    task automatic t_io_legality;
        prom_wen = 1'b1;
        mode_dword = 1'b0;
        access("R6 odd word", 1'b0, 1'b0, 2'd1, 5'h03, '0, 0);
        access("R6 dword mode0", 1'b0, 1'b0, 2'd2, 5'h00, '0, 0);
        access("R6 odd word write", 1'b1, 1'b0, 2'd1, 5'h05, 32'h1234, 0);
        access("R6 byte5 kept", 1'b0, 1'b0, 2'd0, 5'h05, '0, 1);
        access("R6 byte6 kept", 1'b0, 1'b0, 2'd0, 5'h06, '0, 1);
        access("R6 reserved size", 1'b0, 1'b0, 2'd3, 5'h00, '0, 0);
        mode_dword = 1'b1;
        access("R5 dword 8", 1'b0, 1'b0, 2'd2, 5'h08, '0, 1);
        access("R5 misaligned dword", 1'b0, 1'b0, 2'd2, 5'h06, '0, 0);
        access("R5 byte mode1", 1'b0, 1'b0, 2'd0, 5'h01, '0, 0);
        access("R5 word mode1", 1'b0, 1'b0, 2'd1, 5'h02, '0, 0);
        access("R6 byte write mode1", 1'b1, 1'b0, 2'd0, 5'h01, 32'h5A, 0);
        access("R5 dword write 12", 1'b1, 1'b0, 2'd2, 5'h0C, 32'hDEAD_BEEF, 1);
        mode_dword = 1'b0;
        for (int i = 12; i < 16; i++) access("R7 dword lanes", 1'b0, 1'b0, 2'd0, 5'(i), '0, 1);
        access("R6 byte1 kept", 1'b0, 1'b0, 2'd0, 5'h01, '0, 1);
    endtask

    task automatic t_io_regs;
        rp_rdata = 32'h1357_9BDF;
        access("R8 word read 0x12", 1'b0, 1'b0, 2'd1, 5'h12, '0, 2);
        access("R8 dword write 0x14", 1'b1, 1'b0, 2'd2, 5'h14, 32'hCAFE_F00D, 2);
        access("R8 byte refused", 1'b0, 1'b0, 2'd0, 5'h11, '0, 0);
        access("R8 byte write refused", 1'b1, 1'b0, 2'd0, 5'h11, 32'h3C, 0);
        mode_dword = 1'b1;
        rp_rdata = 32'h8642_0ACE;
        access("R11 dword read mode1", 1'b0, 1'b0, 2'd2, 5'h18, '0, 2);
        mode_dword = 1'b0;
    endtask

    task automatic t_mem_store;
        prom_wen = 1'b1;
        mode_dword = 1'b1;
        access("R9 byte mode ignored", 1'b0, 1'b1, 2'd0, 5'h03, '0, 1);
        access("R9 dword wrap", 1'b0, 1'b1, 2'd2, 5'h0E, '0, 1);
        access("R9 odd word", 1'b0, 1'b1, 2'd1, 5'h07, '0, 1);
        access("R9 word write wrap", 1'b1, 1'b1, 2'd1, 5'h0F, 32'hA55A, 1);
        mode_dword = 1'b0;
        access("R9 byte 15 after wrap", 1'b0, 1'b0, 2'd0, 5'h0F, '0, 1);
        access("R9 byte 0 after wrap", 1'b0, 1'b0, 2'd0, 5'h00, '0, 1);
        access("R9 reserved refused", 1'b0, 1'b1, 2'd3, 5'h00, '0, 0);
    endtask

    task automatic t_mem_regs;
        rp_rdata = 32'hF0E1_D2C3;
        access("R10 word read", 1'b0, 1'b1, 2'd1, 5'h1A, '0, 2);
        access("R10 dword write", 1'b1, 1'b1, 2'd2, 5'h14, 32'h0BAD_CAFE, 2);
        access("R10 byte refused", 1'b0, 1'b1, 2'd0, 5'h15, '0, 0);
        access("R10 byte write refused", 1'b1, 1'b1, 2'd0, 5'h15, 32'h66, 0);
        access("R10 store untouched", 1'b0, 1'b0, 2'd0, 5'h05, '0, 1);
    endtask

    task automatic t_timing;
        mode_dword = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_mem = 1'b0;
        req_size = 2'd0; req_addr = 5'h01;
        @(negedge clk);
        req_addr = 5'h02;
        #1;
        check("R2 first reply valid", 32'(rd_valid), 32'd1);
        check("R2 first reply data", rd_data, 32'(model[1]));
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R2 second reply valid", 32'(rd_valid), 32'd1);
        check("R2 second reply data", rd_data, 32'(model[2]));
        @(negedge clk);
        #1;
        check("R2 reply ends", 32'(rd_valid), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_preload();
        t_write_gate();
        t_io_legality();
        t_io_regs();
        t_mem_store();
        t_mem_regs();
        t_timing();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule